// File: doc/BRIEF.md
# Mirrored Dual Scratchpad

This block is a two-port scratchpad for a microcoded datapath. A large wide-side array of 1024 words and a small narrow-side array of 64 words are each read through their own address. Both are written through one shared write port fed from a result bus. Each read port returns its word one clock after the address is presented, so both operands reach the arithmetic unit together.

The narrow array is an exact copy of the bottom 64 words of the wide array. Any write that lands on one of those 64 indices updates both arrays on the same clock edge, whichever side the write names. As a result, either read port may be used to fetch a low-index word and the two always agree. Writes to wide-side indices 64 and above touch only the wide array. A write and a read of the same location in the same cycle return the new word (write-first forwarding).

Top module: `scratch_mirror`

## Requirements
- R1: A wide-side read of `wideRdAddr` presented before a rising edge shows that word on `wideRdData` after that edge. The output is held until the next edge.
- R2: A narrow-side read of `narrowRdAddr` presented before a rising edge shows that 32-bit word on `narrowRdData` after that edge.
- R3: `wrDest` selects the write target: 2'b00 no write, 2'b01 wide side, 2'b10 narrow side. The value 2'b11 is reserved and writes nothing.
- R4: A wide-side write (2'b01) to an index of 64 or above changes only that wide word. Narrow word `wrAddr[5:0]` is left unchanged.
- R5: A wide-side write (2'b01) to an index below 64 also stores `wrData` into the narrow word of the same index, on the same edge.
- R6: A narrow-side write (2'b10) stores `wrData` into narrow word `wrAddr[5:0]` and into wide word `wrAddr[5:0]`. Bits 9:6 of `wrAddr` are ignored, so no wide word at 64 or above is changed.
- R7: When a write and a read target the same resulting word in the same cycle, the read port returns the newly written data (write-first).
- R8: While `rstN` is low, both read outputs are zero. Reset does not clear either array, so words written before reset read back unchanged afterwards.
- R9: For any index below 64 that has been written, reading it on both ports in the same cycle gives identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the read registers |
| wideRdAddr | input | 10 | Wide-side read index |
| narrowRdAddr | input | 6 | Narrow-side read index |
| wrDest | input | 2 | Write destination select (none, wide, narrow, reserved) |
| wrAddr | input | 10 | Write index |
| wrData | input | 32 | Result-bus write data |
| wideRdData | output | 32 | Registered wide-side read data |
| narrowRdData | output | 32 | Registered narrow-side read data |

## Verification
If the two copies drift apart, the drift shows up as a mismatch between `wideRdData` and `narrowRdData` one cycle after both ports are pointed at the same low index. A misrouted write shows up when the wrong word is read back on the following cycle. A write that spills above index 63 from a narrow-side request, or a wide write that fails to reach the narrow copy, is caught on the first later read of either the spilled word or the stale narrow word. A broken forwarding path is visible in the very cycle after a same-address write and read.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

  typedef enum logic [1:0] {
    DEST_NONE   = 2'b00,
    DEST_WIDE   = 2'b01,
    DEST_NARROW = 2'b10,
    DEST_RSVD   = 2'b11
  } destSel_e;

  typedef struct packed {
    logic wideWe;
    logic narrowWe;
    logic wideByp;
    logic narrowByp;
  } strobe_t;

endpackage

// File: rtl/scratch_ctrl.sv
module scratch_ctrl
  import scratch_pkg::*;
#(
  parameter int WIDE_AW   = 10,
  parameter int NARROW_AW = 6
) (
  input  logic [1:0]           wrDest,
  input  logic [WIDE_AW-1:0]   wrAddr,
  input  logic [WIDE_AW-1:0]   wideRdAddr,
  input  logic [NARROW_AW-1:0] narrowRdAddr,
  output logic [WIDE_AW-1:0]   wideWrIdx,
  output logic [NARROW_AW-1:0] narrowWrIdx,
  output strobe_t              stb
);

  localparam int UPPER_W = WIDE_AW - NARROW_AW;

  logic lowHit;
  logic destWide;
  logic destNarrow;

  assign destWide   = (wrDest == DEST_WIDE);
  assign destNarrow = (wrDest == DEST_NARROW);
  assign lowHit     = (wrAddr[WIDE_AW-1:NARROW_AW] == '0);

  assign narrowWrIdx = wrAddr[NARROW_AW-1:0];
  assign wideWrIdx   = destNarrow ? {{UPPER_W{1'b0}}, wrAddr[NARROW_AW-1:0]} : wrAddr;

  always_comb begin
    stb           = '0;
    stb.wideWe    = destWide | destNarrow;
    stb.narrowWe  = destNarrow | (destWide & lowHit);
    stb.wideByp   = stb.wideWe & (wideWrIdx == wideRdAddr);
    stb.narrowByp = stb.narrowWe & (narrowWrIdx == narrowRdAddr);
  end

endmodule

// File: rtl/scratch_datapath.sv
module scratch_datapath
  import scratch_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int WIDE_DEPTH   = 1024,
  parameter int NARROW_DEPTH = 64,
  localparam int WIDE_AW     = $clog2(WIDE_DEPTH),
  localparam int NARROW_AW   = $clog2(NARROW_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [WIDE_AW-1:0]   wideWrIdx,
  input  logic [NARROW_AW-1:0] narrowWrIdx,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [WIDE_AW-1:0]   wideRdAddr,
  input  logic [NARROW_AW-1:0] narrowRdAddr,
  output logic [DATA_W-1:0]    wideRdData,
  output logic [DATA_W-1:0]    narrowRdData
);

  logic [DATA_W-1:0] wideMem   [WIDE_DEPTH];
  logic [DATA_W-1:0] narrowMem [NARROW_DEPTH];

  // Storage arrays are never reset.
  always_ff @(posedge clk) begin
    if (stb.wideWe) begin
      wideMem[wideWrIdx] <= wrData;
    end
    if (stb.narrowWe) begin
      narrowMem[narrowWrIdx] <= wrData;
    end
  end

  // Registered read ports with write-first forwarding.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideRdData   <= '0;
      narrowRdData <= '0;
    end else begin
      wideRdData   <= stb.wideByp   ? wrData : wideMem[wideRdAddr];
      narrowRdData <= stb.narrowByp ? wrData : narrowMem[narrowRdAddr];
    end
  end

endmodule

// File: rtl/scratch_mirror.sv
module scratch_mirror
  import scratch_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int WIDE_DEPTH   = 1024,
  parameter int NARROW_DEPTH = 64,
  localparam int WIDE_AW     = $clog2(WIDE_DEPTH),
  localparam int NARROW_AW   = $clog2(NARROW_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WIDE_AW-1:0]   wideRdAddr,
  input  logic [NARROW_AW-1:0] narrowRdAddr,
  input  logic [1:0]           wrDest,
  input  logic [WIDE_AW-1:0]   wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    wideRdData,
  output logic [DATA_W-1:0]    narrowRdData
);

  strobe_t              stb;
  logic [WIDE_AW-1:0]   wideWrIdx;
  logic [NARROW_AW-1:0] narrowWrIdx;

  scratch_ctrl #(
    .WIDE_AW  (WIDE_AW),
    .NARROW_AW(NARROW_AW)
  ) u_ctrl (
    .wrDest      (wrDest),
    .wrAddr      (wrAddr),
    .wideRdAddr  (wideRdAddr),
    .narrowRdAddr(narrowRdAddr),
    .wideWrIdx   (wideWrIdx),
    .narrowWrIdx (narrowWrIdx),
    .stb         (stb)
  );

  scratch_datapath #(
    .DATA_W      (DATA_W),
    .WIDE_DEPTH  (WIDE_DEPTH),
    .NARROW_DEPTH(NARROW_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wideWrIdx   (wideWrIdx),
    .narrowWrIdx (narrowWrIdx),
    .wrData      (wrData),
    .wideRdAddr  (wideRdAddr),
    .narrowRdAddr(narrowRdAddr),
    .wideRdData  (wideRdData),
    .narrowRdData(narrowRdData)
  );

endmodule

// File: rtl/scratch_mirror_chk.sv
module scratch_mirror_chk #(
  parameter int DATA_W       = 32,
  parameter int WIDE_DEPTH   = 1024,
  parameter int NARROW_DEPTH = 64,
  localparam int WIDE_AW     = $clog2(WIDE_DEPTH),
  localparam int NARROW_AW   = $clog2(NARROW_DEPTH),
  localparam int UPPER_W     = WIDE_AW - NARROW_AW
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [WIDE_AW-1:0]   wideRdAddr,
  input logic [NARROW_AW-1:0] narrowRdAddr,
  input logic [1:0]           wrDest,
  input logic [WIDE_AW-1:0]   wrAddr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    wideRdData,
  input logic [DATA_W-1:0]    narrowRdData
);

  logic                    prevReset;
  logic                    armed;
  logic [NARROW_DEPTH-1:0] lowWritten;
  logic [WIDE_AW-1:0]      narrowRdExt;
  logic [WIDE_AW-1:0]      narrowWrExt;
  logic                    wideHit;
  logic                    narrowFromWide;
  logic                    narrowFromNarrow;
  logic                    lowTouched;
  logic                    mirrorProbe;

  assign narrowRdExt      = {{UPPER_W{1'b0}}, narrowRdAddr};
  assign narrowWrExt      = {{UPPER_W{1'b0}}, wrAddr[NARROW_AW-1:0]};
  assign wideHit          = (wrDest == 2'b01 && wrAddr == wideRdAddr) ||
                            (wrDest == 2'b10 && narrowWrExt == wideRdAddr);
  assign narrowFromWide   = (wrDest == 2'b01) && (wrAddr == narrowRdExt);
  assign narrowFromNarrow = (wrDest == 2'b10) && (wrAddr[NARROW_AW-1:0] == narrowRdAddr);
  assign lowTouched       = (wrDest == 2'b10) ||
                            (wrDest == 2'b01 && wrAddr[WIDE_AW-1:NARROW_AW] == '0);
  assign mirrorProbe      = (wideRdAddr == narrowRdExt) &&
                            (lowWritten[narrowRdAddr] || narrowFromWide || narrowFromNarrow);

  always_ff @(posedge clk) begin
    prevReset <= !rstN;
    if (lowTouched) begin
      lowWritten[wrAddr[NARROW_AW-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_reset_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    prevReset |-> (wideRdData == '0 && narrowRdData == '0));

  assert_wide_forward_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(wideHit) |-> wideRdData == $past(wrData));

  assert_wide_to_narrow_R5: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(narrowFromWide) |-> narrowRdData == $past(wrData));

  assert_narrow_dest_R6: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(narrowFromNarrow) |-> narrowRdData == $past(wrData));

  assert_copies_agree_R9: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(mirrorProbe) |-> wideRdData == narrowRdData);

endmodule

bind scratch_mirror scratch_mirror_chk #(
  .DATA_W      (DATA_W),
  .WIDE_DEPTH  (WIDE_DEPTH),
  .NARROW_DEPTH(NARROW_DEPTH)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wideRdAddr  (wideRdAddr),
  .narrowRdAddr(narrowRdAddr),
  .wrDest      (wrDest),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .wideRdData  (wideRdData),
  .narrowRdData(narrowRdData)
);

// File: tb/sim_scratch_mirror.sv
module sim_scratch_mirror;

  localparam int WD = 1024;
  localparam int ND = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  wideRdAddr = '0;
  logic [5:0]  narrowRdAddr = '0;
  logic [1:0]  wrDest = 2'b00;
  logic [9:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] wideRdData;
  logic [31:0] narrowRdData;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  typedef struct {
    bit          chkW;
    bit          chkN;
    logic [31:0] expW;
    logic [31:0] expN;
    string       tag;
  } exp_t;

  exp_t sbQ[$];

  logic [31:0] mWide   [WD];
  bit          vWide   [WD];
  logic [31:0] mNarrow [ND];
  bit          vNarrow [ND];

  always #4 clk = ~clk;

  scratch_mirror u0 (
    .clk(clk), .rstN(rstN),
    .wideRdAddr(wideRdAddr), .narrowRdAddr(narrowRdAddr),
    .wrDest(wrDest), .wrAddr(wrAddr), .wrData(wrData),
    .wideRdData(wideRdData), .narrowRdData(narrowRdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one call is one clock cycle; expectations follow the requirements.
  task automatic step(input logic [1:0] dest, input logic [9:0] addr, input logic [31:0] data,
                      input logic [9:0] ra, input logic [5:0] rm, input string tag);
    exp_t e;
    @(negedge clk);
    wrDest = dest; wrAddr = addr; wrData = data;
    wideRdAddr = ra; narrowRdAddr = rm;
    if (dest == 2'b01) begin
      mWide[addr] = data; vWide[addr] = 1;
      if (addr < 10'(ND)) begin
        mNarrow[addr[5:0]] = data; vNarrow[addr[5:0]] = 1;
      end
    end else if (dest == 2'b10) begin
      mNarrow[addr[5:0]] = data; vNarrow[addr[5:0]] = 1;
      mWide[{4'b0, addr[5:0]}] = data; vWide[{4'b0, addr[5:0]}] = 1;
    end
    e.chkW = vWide[ra];   e.expW = mWide[ra];
    e.chkN = vNarrow[rm]; e.expN = mNarrow[rm];
    e.tag  = tag;
    sbQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrDest = 2'b00;
    end
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        e = sbQ.pop_front();
        if (e.chkW) check({e.tag, " wide"}, wideRdData, e.expW);
        if (e.chkN) check({e.tag, " narrow"}, narrowRdData, e.expN);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < WD; i++) vWide[i] = 0;
    for (int i = 0; i < ND; i++) vNarrow[i] = 0;

    repeat (3) @(negedge clk);
    check("R8 reset wide", wideRdData, 32'h0);
    check("R8 reset narrow", narrowRdData, 32'h0);
    rstN = 1'b1;

    // Fill every low word through the narrow side; same-cycle reads forward (R6, R7).
    for (int i = 0; i < ND; i++)
      step(2'b10, 10'(i), $urandom, 10'(i), 6'(i), "R7 sweep");

    step(2'b01, 10'd100, 32'hA1A1_0001, 10'd0, 6'd0, "R5 setup");
    step(2'b00, 10'd0, 32'h0, 10'd100, 6'd36, "R1 R2 read latency");
    step(2'b01, 10'd164, 32'hB2B2_0002, 10'd1, 6'd1, "R4 setup");
    step(2'b00, 10'd0, 32'h0, 10'd164, 6'd36, "R4 high wide write");
    step(2'b00, 10'd0, 32'h0, 10'd36, 6'd36, "R4 low copy untouched");
    step(2'b01, 10'd5, 32'hC3C3_0003, 10'd2, 6'd2, "R5 setup");
    step(2'b00, 10'd0, 32'h0, 10'd5, 6'd5, "R5 low wide write");
    step(2'b01, 10'h3C7, 32'hD4D4_0004, 10'd3, 6'd3, "R6 setup");
    step(2'b10, 10'h3C7, 32'hE5E5_0005, 10'd4, 6'd4, "R6 setup");
    step(2'b00, 10'd0, 32'h0, 10'h3C7, 6'd7, "R6 upper bits ignored");
    step(2'b00, 10'd0, 32'h0, 10'd7, 6'd7, "R6 both copies");
    step(2'b11, 10'd9, 32'hF6F6_0006, 10'd9, 6'd9, "R3 reserved");
    step(2'b00, 10'd9, 32'h1111_2222, 10'd9, 6'd9, "R3 none");
    step(2'b01, 10'd300, 32'h7777_0007, 10'd300, 6'd12, "R7 wide forward");
    step(2'b10, 10'd20, 32'h8888_0008, 10'd20, 6'd20, "R7 narrow forward");
    step(2'b01, 10'd21, 32'h9999_0009, 10'd21, 6'd21, "R7 mirrored forward");

    for (int i = 0; i < 1500; i++) begin
      logic [1:0] d;
      logic [9:0] a;
      logic [9:0] ra;
      logic [5:0] rm;
      d  = 2'($urandom);
      a  = ($urandom % 2) ? 10'($urandom % ND) : 10'($urandom);
      rm = 6'($urandom);
      ra = ($urandom % 2) ? {4'b0, rm} : 10'($urandom);
      if (ra == {4'b0, rm}) step(d, a, $urandom, ra, rm, "R9 mirror");
      else                  step(d, a, $urandom, ra, rm, "R1 R2 random");
    end

    idle(3);
    rstN = 1'b0;
    #1;
    check("R8 second reset wide", wideRdData, 32'h0);
    check("R8 second reset narrow", narrowRdData, 32'h0);
    idle(2);
    rstN = 1'b1;
    step(2'b00, 10'd0, 32'h0, 10'd300, 6'd20, "R8 contents kept");
    step(2'b00, 10'd0, 32'h0, 10'd21, 6'd36, "R8 contents kept");
    idle(3);
    finish_run();
  end

endmodule